// File: doc/BRIEF.md
# Per-Thread Reorder Buffer Share Controller

This block decides how many reorder-buffer slots each hardware thread of a multithreaded core may hold. It does not store any instructions. It keeps one occupancy count per thread. These counts go up on allocate pulses from dispatch and down on release pulses from commit or squash. Each pulse carries a thread id.

From the occupancy counts and the per-thread limits, the block reports three things to the dispatch stage every cycle: a free count for each thread, a free count for the whole buffer, and a stall flag for each thread.

The limits follow one of three sharing schemes, chosen by a 2-bit policy input:
- **Open sharing:** every thread may fill the whole buffer.
- **Even split:** the buffer is split evenly among the threads marked active.
- **Capped:** every thread is capped at a programmable value. A lone active thread gets the full buffer.

The limits are recomputed from the policy, the active-thread mask and the cap value, and registered on every clock edge. A change of the active set therefore takes effect one cycle later. Allocations that would exceed a limit are refused and flagged. Releases of a thread that holds nothing are flagged, and the count stays at zero.

Top module: `rob_share_ctrl`

## Requirements
- R1: With policy code 0 (open sharing), every thread's limit equals DEPTH.
- R2: With policy code 1 (even split), each active thread's limit is DEPTH divided (integer division) by the number of active threads. Inactive threads, and all threads when none is active, get DEPTH / THREADS.
- R3: With policy code 2 (capped), each thread's limit is the cap input clamped to DEPTH. When exactly one thread is active, that thread's limit is DEPTH.
- R4: Limits take the value implied by the policy, mask and cap one clock edge after those inputs change. While reset is held, all limits are 0.
- R5: A thread's free count is its limit minus its occupancy, floored at 0 when the limit has dropped below the occupancy. The total free count is DEPTH minus the sum of all occupancies.
- R6: A thread's stall flag is 1 when its free count is 0 or the total free count is 0.
- R7: An allocate pulse for a stalled thread is refused. The occupancy does not change, and the allocation error output is 1 in the following cycle.
- R8: The sum of occupancies never exceeds DEPTH.
- R9: A release pulse for a thread with zero occupancy leaves the count at 0. The release error output is 1 in the following cycle.
- R10: Policy code 3 is illegal. The config error output is 1 in the following cycle, and all limits are 0.
- R11: An accepted allocate and a release for the same non-empty thread in the same cycle leave its occupancy unchanged.
- R12: While reset is held, every occupancy is 0, every error output is 0 and the total free count is DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Sharing scheme: 0 open, 1 even split, 2 capped, 3 illegal |
| cap_i | input | CNT_W | Per-thread cap for the capped scheme |
| active_i | input | THREADS | Active-thread mask, one bit per thread |
| alloc_vld_i | input | 1 | Allocate one slot |
| alloc_tid_i | input | TID_W | Thread of the allocation |
| rel_vld_i | input | 1 | Release one slot |
| rel_tid_i | input | TID_W | Thread of the release |
| thread_free_o | output | THREADS*CNT_W | Per-thread free counts; thread t in bits [t*CNT_W +: CNT_W] |
| total_free_o | output | CNT_W | Free slots in the whole buffer |
| stall_o | output | THREADS | Per-thread stall flags |
| alloc_err_o | output | 1 | Previous cycle's allocation was refused |
| rel_err_o | output | 1 | Previous cycle's release hit an empty thread |
| cfg_err_o | output | 1 | Previous cycle's policy code was illegal |

## Verification
The hardest case to reach is a limit that falls below a thread's existing occupancy. The free count must then floor at zero, and the stall must hold until enough releases have drained the thread below the new limit. The bench builds this case in three steps:
1. It makes a single thread active under the even split, so that thread may fill most of the buffer.
2. It allocates twenty slots to that thread.
3. It widens the active mask, which cuts the limit to eight.

It then releases slots one at a time and watches for the exact release that makes the free count nonzero again. A second awkward case is a refused allocation. It is confirmed through a later release: the free count rises by exactly one, which proves the refused pulse left no hidden increment behind.

// File: rtl/rob_share_pkg.sv
package rob_share_pkg;

    typedef enum logic [1:0] {
        POL_OPEN  = 2'd0,
        POL_SPLIT = 2'd1,
        POL_CAP   = 2'd2,
        POL_BAD   = 2'd3
    } share_pol_e;

endpackage

// File: rtl/rob_limit_calc.sv
module rob_limit_calc
    import rob_share_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int DEPTH   = 32,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic [1:0]                      policy_i,
    input  logic [CNT_W-1:0]                cap_i,
    input  logic [THREADS-1:0]              active_i,
    output logic [THREADS-1:0][CNT_W-1:0]   limit_o
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    // Even share of the buffer among n threads, n in 1..THREADS.
    function automatic logic [CNT_W-1:0] share_of(input logic [CNT_W-1:0] n);
        logic [CNT_W-1:0] r;
        r = '0;
        for (int k = 1; k <= THREADS; k++) begin
            if (n == CNT_W'(k)) r = CNT_W'(DEPTH / k);
        end
        return r;
    endfunction

    logic [CNT_W-1:0] n_active;
    logic [CNT_W-1:0] cap_clamped;
    logic [CNT_W-1:0] split_base;
    logic [CNT_W-1:0] split_share;

    always_comb begin
        n_active = '0;
        for (int t = 0; t < THREADS; t++) begin
            n_active = n_active + CNT_W'(active_i[t]);
        end
        cap_clamped = (cap_i > DEPTH_C) ? DEPTH_C : cap_i;
        split_base  = share_of(CNT_W'(THREADS));
        split_share = share_of(n_active);
    end

    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            unique case (share_pol_e'(policy_i))
                POL_OPEN:  limit_o[t] = DEPTH_C;
                POL_SPLIT: limit_o[t] = (n_active != '0 && active_i[t]) ? split_share
                                                                        : split_base;
                POL_CAP:   limit_o[t] = (n_active == CNT_W'(1) && active_i[t]) ? DEPTH_C
                                                                               : cap_clamped;
                default:   limit_o[t] = '0;
            endcase
        end
    end

endmodule

// File: rtl/rob_occ_track.sv
module rob_occ_track #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] occ_o,
    output logic             empty_o
);

    typedef struct packed {
        logic [CNT_W-1:0] occ;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic       dec_eff;

    always_comb begin
        st_d    = st_q;
        dec_eff = dec_i && (st_q.occ != '0);
        if (inc_i && !dec_eff) begin
            st_d.occ = st_q.occ + CNT_W'(1);
        end else if (!inc_i && dec_eff) begin
            st_d.occ = st_q.occ - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign occ_o   = st_q.occ;
    assign empty_o = (st_q.occ == '0);

    // R9: a release on an empty thread keeps the count at zero
    a_r9_empty_release: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i && occ_o == '0) |=> (occ_o == '0));

    // R11: matched allocate and release leave a non-empty count unchanged
    a_r11_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i && occ_o != '0) |=> $stable(occ_o));

endmodule

// File: rtl/rob_share_ctrl.sv
module rob_share_ctrl
    import rob_share_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int DEPTH   = 32,
    parameter int CNT_W   = $clog2(DEPTH + 1),
    parameter int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 policy_i,
    input  logic [CNT_W-1:0]           cap_i,
    input  logic [THREADS-1:0]         active_i,
    input  logic                       alloc_vld_i,
    input  logic [TID_W-1:0]           alloc_tid_i,
    input  logic                       rel_vld_i,
    input  logic [TID_W-1:0]           rel_tid_i,
    output logic [THREADS*CNT_W-1:0]   thread_free_o,
    output logic [CNT_W-1:0]           total_free_o,
    output logic [THREADS-1:0]         stall_o,
    output logic                       alloc_err_o,
    output logic                       rel_err_o,
    output logic                       cfg_err_o
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic [THREADS-1:0][CNT_W-1:0] limit;
        logic                          alloc_err;
        logic                          rel_err;
        logic                          cfg_err;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [THREADS-1:0][CNT_W-1:0] limit_new;
    logic [THREADS-1:0][CNT_W-1:0] occ;
    logic [THREADS-1:0][CNT_W-1:0] free_cnt;
    logic [THREADS-1:0]            empty;
    logic [THREADS-1:0]            inc;
    logic [THREADS-1:0]            dec;
    logic [CNT_W-1:0]              total_occ;
    logic [CNT_W-1:0]              total_free;
    logic                          alloc_in_rng;
    logic                          rel_in_rng;
    logic                          alloc_sel_stall;
    logic                          rel_sel_empty;
    logic                          alloc_ok;

    rob_limit_calc #(
        .THREADS (THREADS),
        .DEPTH   (DEPTH),
        .CNT_W   (CNT_W)
    ) limit_calc_i (
        .policy_i (policy_i),
        .cap_i    (cap_i),
        .active_i (active_i),
        .limit_o  (limit_new)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        rob_occ_track #(
            .CNT_W (CNT_W)
        ) occ_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (inc[t]),
            .dec_i   (dec[t]),
            .occ_o   (occ[t]),
            .empty_o (empty[t])
        );
        assign thread_free_o[t*CNT_W +: CNT_W] = free_cnt[t];
    end

    // Occupancy, free counts and stall flags
    always_comb begin
        total_occ = '0;
        for (int t = 0; t < THREADS; t++) begin
            total_occ   = total_occ + occ[t];
            free_cnt[t] = (st_q.limit[t] > occ[t]) ? (st_q.limit[t] - occ[t]) : '0;
        end
        total_free = DEPTH_C - total_occ;
        for (int t = 0; t < THREADS; t++) begin
            stall_o[t] = (free_cnt[t] == '0) || (total_free == '0);
        end
    end

    // Decode of the allocate and release pulses
    always_comb begin
        alloc_in_rng    = (int'(alloc_tid_i) < THREADS);
        rel_in_rng      = (int'(rel_tid_i) < THREADS);
        alloc_sel_stall = 1'b1;
        rel_sel_empty   = 1'b1;
        for (int t = 0; t < THREADS; t++) begin
            if (alloc_tid_i == TID_W'(t)) alloc_sel_stall = stall_o[t];
            if (rel_tid_i == TID_W'(t))   rel_sel_empty   = empty[t];
        end
        alloc_ok = alloc_vld_i && alloc_in_rng && !alloc_sel_stall;
        for (int t = 0; t < THREADS; t++) begin
            inc[t] = alloc_ok && (alloc_tid_i == TID_W'(t));
            dec[t] = rel_vld_i && rel_in_rng && (rel_tid_i == TID_W'(t));
        end
    end

    // Next registered state
    always_comb begin
        st_d           = st_q;
        st_d.limit     = limit_new;
        st_d.alloc_err = alloc_vld_i && !alloc_ok;
        st_d.rel_err   = rel_vld_i && (!rel_in_rng || rel_sel_empty);
        st_d.cfg_err   = (share_pol_e'(policy_i) == POL_BAD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign total_free_o = total_free;
    assign alloc_err_o  = st_q.alloc_err;
    assign rel_err_o    = st_q.rel_err;
    assign cfg_err_o    = st_q.cfg_err;

    // R8: occupancy sum stays within the buffer
    a_r8_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
        total_occ <= DEPTH_C);

    // R7: an allocation for a stalled thread is flagged next cycle
    a_r7_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_vld_i && alloc_in_rng && alloc_sel_stall) |=> alloc_err_o);

    // R10: illegal policy is flagged and blocks every thread
    a_r10_cfg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd3) |=> (cfg_err_o && stall_o == '1));

    // R1: open sharing grants the whole buffer to thread 0
    a_r1_open_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd0) |=> (st_q.limit[0] == DEPTH_C));

endmodule

// File: tb/rob_share_ctrl_tb_top.sv
module rob_share_ctrl_tb_top;

    localparam int THREADS = 4;
    localparam int DEPTH   = 32;
    localparam int CNT_W   = 6;
    localparam int TID_W   = 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [1:0]               policy_i = 2'd0;
    logic [CNT_W-1:0]         cap_i = '0;
    logic [THREADS-1:0]       active_i = '0;
    logic                     alloc_vld_i = 1'b0;
    logic [TID_W-1:0]         alloc_tid_i = '0;
    logic                     rel_vld_i = 1'b0;
    logic [TID_W-1:0]         rel_tid_i = '0;
    logic [THREADS*CNT_W-1:0] thread_free_o;
    logic [CNT_W-1:0]         total_free_o;
    logic [THREADS-1:0]       stall_o;
    logic                     alloc_err_o;
    logic                     rel_err_o;
    logic                     cfg_err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rob_share_ctrl #(
        .THREADS (THREADS),
        .DEPTH   (DEPTH),
        .CNT_W   (CNT_W),
        .TID_W   (TID_W)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .policy_i      (policy_i),
        .cap_i         (cap_i),
        .active_i      (active_i),
        .alloc_vld_i   (alloc_vld_i),
        .alloc_tid_i   (alloc_tid_i),
        .rel_vld_i     (rel_vld_i),
        .rel_tid_i     (rel_tid_i),
        .thread_free_o (thread_free_o),
        .total_free_o  (total_free_o),
        .stall_o       (stall_o),
        .alloc_err_o   (alloc_err_o),
        .rel_err_o     (rel_err_o),
        .cfg_err_o     (cfg_err_o)
    );

    function automatic int free_of(int t);
        return int'(thread_free_o[t*CNT_W +: CNT_W]);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(logic [1:0] pol, logic [CNT_W-1:0] cap, logic [THREADS-1:0] act);
        @(negedge clk);
        rst_n       = 1'b0;
        policy_i    = pol;
        cap_i       = cap;
        active_i    = act;
        alloc_vld_i = 1'b0;
        rel_vld_i   = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic alloc(int t, int n);
        for (int i = 0; i < n; i++) begin
            alloc_vld_i = 1'b1;
            alloc_tid_i = TID_W'(t);
            step();
        end
        alloc_vld_i = 1'b0;
    endtask

    task automatic rel(int t, int n);
        for (int i = 0; i < n; i++) begin
            rel_vld_i = 1'b1;
            rel_tid_i = TID_W'(t);
            step();
        end
        rel_vld_i = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        policy_i = 2'd0;
        active_i = '1;
        step();
        step();
        chk("R12", "total free in reset", int'(total_free_o), DEPTH);
        chk("R12", "error flags in reset", int'({alloc_err_o, rel_err_o, cfg_err_o}), 0);
        chk("R4", "thread0 free in reset", free_of(0), 0);
        rst_n = 1'b1;
        step();
        chk("R4", "thread0 free after reset", free_of(0), DEPTH);
    endtask

    task automatic t_open();
        do_reset(2'd0, '0, 4'b1111);
        for (int t = 0; t < THREADS; t++) chk("R1", "open limit", free_of(t), DEPTH);
        alloc(1, 3);
        chk("R5", "thread1 free", free_of(1), 29);
        chk("R5", "thread0 free", free_of(0), 32);
        chk("R5", "total free", int'(total_free_o), 29);
    endtask

    task automatic t_split();
        do_reset(2'd1, '0, 4'b1111);
        for (int t = 0; t < THREADS; t++) chk("R2", "split of four", free_of(t), 8);
        alloc(1, 3);
        chk("R2", "thread1 free", free_of(1), 5);
        active_i = 4'b0011;
        #1;
        chk("R4", "limit not yet updated", free_of(0), 8);
        step();
        chk("R2", "thread0 split of two", free_of(0), 16);
        chk("R2", "thread1 split of two", free_of(1), 13);
        chk("R2", "inactive thread2", free_of(2), 8);
        active_i = 4'b0000;
        step();
        chk("R2", "none active", free_of(0), 8);
        active_i = 4'b0001;
        step();
        chk("R2", "lone active", free_of(0), 32);
    endtask

    task automatic t_cap();
        do_reset(2'd2, 6'd5, 4'b1111);
        for (int t = 0; t < THREADS; t++) chk("R3", "cap limit", free_of(t), 5);
        active_i = 4'b0100;
        step();
        chk("R3", "lone capped thread", free_of(2), 32);
        chk("R3", "inactive capped thread", free_of(0), 5);
        cap_i = 6'd50;
        active_i = 4'b1111;
        step();
        chk("R3", "cap clamped", free_of(0), 32);
    endtask

    task automatic t_reject();
        do_reset(2'd1, '0, 4'b1111);
        alloc(0, 8);
        chk("R6", "thread0 full", free_of(0), 0);
        chk("R6", "stall flags", int'(stall_o), 1);
        chk("R7", "no error on accepted", int'(alloc_err_o), 0);
        alloc(0, 1);
        chk("R7", "refused alloc flag", int'(alloc_err_o), 1);
        step();
        chk("R7", "flag clears", int'(alloc_err_o), 0);
        rel(0, 1);
        chk("R7", "occupancy unchanged by refusal", free_of(0), 1);
    endtask

    task automatic t_total_full();
        do_reset(2'd0, '0, 4'b1111);
        alloc(0, 16);
        alloc(1, 16);
        chk("R8", "total full", int'(total_free_o), 0);
        chk("R6", "all stalled", int'(stall_o), 15);
        chk("R5", "thread2 free", free_of(2), 32);
        alloc(2, 1);
        chk("R8", "overflow refused", int'(alloc_err_o), 1);
        chk("R8", "total still full", int'(total_free_o), 0);
    endtask

    task automatic t_rel_empty();
        do_reset(2'd0, '0, 4'b1111);
        rel(3, 1);
        chk("R9", "release error", int'(rel_err_o), 1);
        chk("R9", "thread3 free", free_of(3), 32);
        alloc(3, 1);
        chk("R9", "no wrap", free_of(3), 31);
        chk("R9", "release flag clears", int'(rel_err_o), 0);
    endtask

    task automatic t_illegal();
        do_reset(2'd3, '0, 4'b1111);
        chk("R10", "config error", int'(cfg_err_o), 1);
        chk("R10", "limit zero", free_of(0), 0);
        chk("R10", "all stalled", int'(stall_o), 15);
        alloc(0, 1);
        chk("R10", "alloc refused", int'(alloc_err_o), 1);
        chk("R10", "total untouched", int'(total_free_o), 32);
        policy_i = 2'd0;
        step();
        chk("R10", "config error clears", int'(cfg_err_o), 0);
        chk("R10", "limit restored", free_of(0), 32);
    endtask

    task automatic t_shrink();
        do_reset(2'd1, '0, 4'b0001);
        alloc(0, 20);
        chk("R5", "thread0 before shrink", free_of(0), 12);
        active_i = 4'b1111;
        step();
        chk("R5", "floored at zero", free_of(0), 0);
        chk("R6", "thread0 stalled", int'(stall_o[0]), 1);
        chk("R5", "total free", int'(total_free_o), 12);
        rel(0, 12);
        chk("R5", "at limit", free_of(0), 0);
        rel(0, 1);
        chk("R5", "below limit", free_of(0), 1);
    endtask

    task automatic t_same_cycle();
        do_reset(2'd0, '0, 4'b1111);
        alloc(2, 4);
        chk("R11", "after alloc", free_of(2), 28);
        alloc_vld_i = 1'b1;
        alloc_tid_i = 2'd2;
        rel_vld_i   = 1'b1;
        rel_tid_i   = 2'd2;
        step();
        alloc_vld_i = 1'b0;
        rel_vld_i   = 1'b0;
        chk("R11", "balanced thread2", free_of(2), 28);
        chk("R11", "balanced total", int'(total_free_o), 28);
    endtask

    initial begin
        t_reset_state();
        t_open();
        t_split();
        t_cap();
        t_reject();
        t_total_full();
        t_rel_empty();
        t_illegal();
        t_shrink();
        t_same_cycle();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule